// File: doc/BRIEF.md
# Time-Shared Transposed Low-Pass FIR Filter

This block is a linear-phase low-pass FIR filter with 138 taps, built in transposed form and time-shared by a factor of six. Each of its 23 stages owns one multiplier and one adder. A six-way multiplexer picks the coefficient for the current slot. The stage's six partial sums live in a short shift chain: each new product-plus-carry value enters at the top and moves one place toward the bottom on every clock. A two-way multiplexer supplies the carry from the neighbouring stage on the last slot of a frame. Because the coefficients are symmetric, only half of them are stored, in a parameter table. Tap k and tap 137-k read the same entry.

A free-running modulo-six counter marks frames. The filter takes one signed 12-bit sample on the first clock of each frame. One frame later it presents a rounded, saturated 12-bit result, marked by a single-cycle valid strobe. A source that delivers one sample every six clocks, aligned to reset release, drives it directly.

Top module: `fold_fir`

## Requirements
- R1: A synchronous active-high reset drives y_out to 0 and y_valid low on the following clock, and clears every stored partial sum.
- R2: A sample is taken only on the first rising edge after reset is released and on every sixth edge after it. Values on x_in at the other five edges of a frame have no effect on any output.
- R3: Before rounding, the result for sample n is the sum over k = 0..137 of h(k)·x(n-k), with zero for samples before reset. Coefficients are signed 16-bit and inputs are signed 12-bit. The table holds entries 0..68 at bit offset 16·k. Tap k uses entry k for k < 69 and entry 137-k otherwise.
- R4: The sum is rounded by adding 2^14 and then shifting arithmetically right by 15 bits.
- R5: A rounded value above 2047 is output as 2047, and one below -2048 is output as -2048.
- R6: The result for a sample taken at edge e appears on y_out at edge e+6, with y_valid high for exactly that one cycle. The frame edge that takes the first sample after reset raises no valid.
- R7: y_out holds its value in every cycle in which y_valid is low.
- R8: A reset during streaming discards all history. Results after it depend only on samples taken after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 12 | Signed input sample, taken at frame start |
| y_out | output | 12 | Signed filtered result, rounded and saturated |
| y_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle, the assertions check four things:
- the reset state;
- the spacing and counter alignment of the valid strobe;
- that the output holds between strobes;
- that the output clamps whenever the final partial sum lies beyond the representable range.

Only the bench's scenarios can show the rest. These cover the arithmetic of the full 138-tap convolution, the mirrored coefficient lookup, the rounding of small values, and that junk driven between frame starts is ignored. They also show that a reset in mid-stream really forgets the history. The bench shows these by comparing every cycle against a behavioural convolution over a queue of past samples.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;

    localparam int TAPS_DEF = 138;
    localparam int CW_DEF   = 16;
    localparam int HALF_DEF = TAPS_DEF / 2;

    // Default half table: a gently rising shape with a small ripple.
    function automatic logic [HALF_DEF*CW_DEF-1:0] default_half_tab();
        logic [HALF_DEF*CW_DEF-1:0] t;
        t = '0;
        for (int k = 0; k < HALF_DEF; k++) begin
            int v;
            v = 30 * k + ((k % 5) - 2) * 50 - 200;
            t[k*CW_DEF +: CW_DEF] = CW_DEF'(v);
        end
        return t;
    endfunction

endpackage

// File: rtl/fold_cnt.sv
module fold_cnt #(
    parameter int FOLD = 6,
    parameter int CNTW = $clog2(FOLD)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [CNTW-1:0] cnt
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CNTW'(FOLD - 1)) cnt_d = '0;
        else                          cnt_d = cnt_q + CNTW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/fold_stage.sv
module fold_stage #(
    parameter int FOLD = 6,
    parameter int CW   = 16,
    parameter int DW   = 12,
    parameter int AW   = 36,
    parameter int CNTW = $clog2(FOLD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNTW-1:0]      cnt,
    input  logic signed [DW-1:0] x,
    input  logic [FOLD*CW-1:0]   coefs,
    input  logic [AW-1:0]        next_head,
    output logic [AW-1:0]        head
);
    typedef struct packed {
        logic [FOLD-1:0][AW-1:0] chain;  // slot 0 is the oldest entry
        logic [AW-1:0]           link;   // neighbour's bottom slot, frame start
    } stage_t;

    stage_t s_d, s_q;
    logic signed [CW-1:0]    coef;
    logic signed [CW+DW-1:0] prod;
    logic signed [AW-1:0]    carry;
    logic signed [AW-1:0]    sum;

    always_comb begin
        coef  = $signed(coefs[cnt*CW +: CW]);
        prod  = coef * x;
        carry = (cnt == CNTW'(FOLD - 1)) ? $signed(s_q.link) : $signed(s_q.chain[1]);
        sum   = AW'(prod) + carry;

        s_d = s_q;
        for (int j = 0; j < FOLD - 1; j++) begin
            s_d.chain[j] = s_q.chain[j+1];
        end
        s_d.chain[FOLD-1] = sum;
        if (cnt == '0) s_d.link = next_head;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head = s_q.chain[0];
endmodule

// File: rtl/fold_quant.sv
module fold_quant #(
    parameter int AW    = 36,
    parameter int OW    = 12,
    parameter int SHIFT = 15
) (
    input  logic [AW-1:0]        acc,
    output logic signed [OW-1:0] q
);
    localparam logic signed [AW:0] HI   = (AW+1)'(2**(OW-1) - 1);
    localparam logic signed [AW:0] LO   = -HI - (AW+1)'(1);
    localparam logic signed [AW:0] HALF = (AW+1)'(2**(SHIFT-1));

    logic signed [AW:0] biased;
    logic signed [AW:0] scaled;

    always_comb begin
        biased = $signed({acc[AW-1], acc}) + HALF;
        scaled = biased >>> SHIFT;
        if (scaled > HI)      q = HI[OW-1:0];
        else if (scaled < LO) q = LO[OW-1:0];
        else                  q = scaled[OW-1:0];
    end
endmodule

// File: rtl/fold_fir.sv
module fold_fir #(
    parameter int TAPS  = fold_fir_pkg::TAPS_DEF,
    parameter int FOLD  = 6,
    parameter int DW    = 12,
    parameter int CW    = fold_fir_pkg::CW_DEF,
    parameter int OW    = 12,
    parameter int SHIFT = CW - 1,
    parameter logic [TAPS/2*CW-1:0] HALF_COEF = fold_fir_pkg::default_half_tab()
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] x_in,
    output logic signed [OW-1:0] y_out,
    output logic                 y_valid
);
    localparam int STAGES = TAPS / FOLD;
    localparam int HALF   = TAPS / 2;
    localparam int AW     = CW + DW + $clog2(TAPS);
    localparam int CNTW   = $clog2(FOLD);

    function automatic logic [CW-1:0] tap_coef(int k);
        int m;
        m = (k < HALF) ? k : TAPS - 1 - k;
        return HALF_COEF[m*CW +: CW];
    endfunction

    typedef struct packed {
        logic [DW-1:0] x;
        logic [OW-1:0] y;
        logic          valid;
        logic          primed;
    } top_t;

    top_t r_d, r_q;
    logic [CNTW-1:0]      cnt_q;
    logic signed [DW-1:0] x_cur;
    logic signed [OW-1:0] y_next;
    logic [AW-1:0]        heads [STAGES+1];

    fold_cnt #(.FOLD(FOLD), .CNTW(CNTW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt_q)
    );

    assign x_cur         = (cnt_q == '0) ? x_in : $signed(r_q.x);
    assign heads[STAGES] = '0;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [FOLD*CW-1:0] cf;
        for (genvar c = 0; c < FOLD; c++) begin : g_coef
            assign cf[c*CW +: CW] = tap_coef(s * FOLD + c);
        end
        fold_stage #(.FOLD(FOLD), .CW(CW), .DW(DW), .AW(AW), .CNTW(CNTW)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .cnt       (cnt_q),
            .x         (x_cur),
            .coefs     (cf),
            .next_head (heads[s+1]),
            .head      (heads[s])
        );
    end

    fold_quant #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_quant (
        .acc (heads[0]),
        .q   (y_next)
    );

    always_comb begin
        r_d = r_q;
        if (cnt_q == '0) begin
            r_d.x      = x_in;
            r_d.y      = y_next;
            r_d.valid  = r_q.primed;
            r_d.primed = 1'b1;
        end else begin
            r_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign y_out   = $signed(r_q.y);
    assign y_valid = r_q.valid;
endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk #(
    parameter int FOLD  = 6,
    parameter int CNTW  = 3,
    parameter int AW    = 36,
    parameter int OW    = 12,
    parameter int SHIFT = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CNTW-1:0]      cnt,
    input logic [AW-1:0]        head0,
    input logic signed [OW-1:0] y_out,
    input logic                 y_valid
);
    localparam longint HI_T = longint'(2**(OW-1)) << SHIFT;
    localparam longint LO_T = -((longint'(2**(OW-1)) + 1) << SHIFT);
    localparam logic signed [OW-1:0] MAXV = OW'(2**(OW-1) - 1);
    localparam logic signed [OW-1:0] MINV = -MAXV - OW'(1);

    logic signed [AW-1:0] h0s;
    int gap;

    assign h0s = $signed(head0);

    always_ff @(posedge clk) begin
        if (rst)               gap <= FOLD;
        else if (y_valid)      gap <= 1;
        else if (gap < FOLD)   gap <= gap + 1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !y_valid));

    assert_valid_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> gap >= FOLD);

    assert_valid_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> cnt == CNTW'(1));

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
        !y_valid |-> $stable(y_out));

    assert_clamp_high_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && longint'(h0s) >= HI_T) |=> y_out == MAXV);

    assert_clamp_low_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && longint'(h0s) <= LO_T) |=> y_out == MINV);
endmodule

bind fold_fir fold_fir_chk #(
    .FOLD(FOLD), .CNTW(CNTW), .AW(AW), .OW(OW), .SHIFT(SHIFT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_q),
    .head0   (heads[0]),
    .y_out   (y_out),
    .y_valid (y_valid)
);

// File: tb/test_fold_fir.sv
module test_fold_fir;
    localparam int TAPS = 138;
    localparam int HALF = TAPS / 2;
    localparam int FOLD = 6;

    function automatic int bcoef(int k);
        return ((k * 37) % 257) * 8 - 600;
    endfunction

    function automatic logic [HALF*16-1:0] btab();
        logic [HALF*16-1:0] t;
        for (int k = 0; k < HALF; k++) t[k*16 +: 16] = 16'(bcoef(k));
        return t;
    endfunction

    function automatic longint htap(int k);
        return longint'(bcoef(k < HALF ? k : TAPS - 1 - k));
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [11:0] x_in = '0;
    logic signed [11:0] y_out;
    logic y_valid;

    fold_fir #(.TAPS(TAPS), .FOLD(FOLD), .HALF_COEF(btab())) i_fold_fir (
        .clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out), .y_valid(y_valid)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string cur_req = "R1";

    longint hist[$];
    longint pend = 0;
    bit have_pend = 1'b0;
    int phase = 0;
    longint exp_out = 0;
    bit exp_valid = 1'b0;

    function automatic longint ref_out();
        longint acc = 0;
        longint r;
        for (int i = 0; i < hist.size(); i++) acc += htap(i) * hist[i];
        r = (acc + 16384) >>> 15;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            phase = 0; hist.delete(); have_pend = 0; exp_out = 0; exp_valid = 0;
        end else begin
            if (phase == 0) begin
                exp_valid = have_pend;
                if (have_pend) exp_out = pend;
                hist.push_front(longint'(x_in));
                if (hist.size() > TAPS) void'(hist.pop_back());
                pend = ref_out();
                have_pend = 1;
            end else begin
                exp_valid = 0;
            end
            phase = (phase + 1) % FOLD;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(y_valid == exp_valid, {cur_req, "/R6 valid"}, longint'(y_valid), longint'(exp_valid));
            chk(longint'(y_out) == exp_out, {cur_req, " y_out"}, longint'(y_out), exp_out);
        end
    end

    // one frame: sample at frame start, junk (or zero) on the other edges
    task automatic frame(longint v, bit junk);
        x_in = 12'(v);
        @(negedge clk);
        for (int i = 1; i < FOLD; i++) begin
            x_in = junk ? 12'($urandom) : 12'(0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            done = 1'b1;
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(y_out == 0 && y_valid == 0, "R1 reset state", longint'(y_out), 0);
        rst = 1'b0;

        // R2 R3 R6: impulse with junk between frame starts
        cur_req = "R2";
        frame(2047, 1);
        for (int i = 0; i < 140; i++) frame(0, 1);

        // R3: random samples
        cur_req = "R3";
        for (int i = 0; i < 60; i++) frame(longint'($signed(12'($urandom))), 1);

        // R4: small values stress rounding
        cur_req = "R4";
        for (int i = 0; i < 40; i++) frame(longint'($urandom_range(0, 40)) - 20, 0);

        // R5: saturate high then low
        cur_req = "R5";
        for (int i = 0; i < 150; i++) frame(2047, 1);
        chk(y_out == 12'sd2047, "R5 clamp high", longint'(y_out), 2047);
        for (int i = 0; i < 150; i++) frame(-2048, 1);
        chk(y_out == -12'sd2048, "R5 clamp low", longint'(y_out), -2048);

        // R7: hold during idle slots covered by per-cycle compare
        cur_req = "R7";
        for (int i = 0; i < 10; i++) frame(longint'(i * 100 - 400), 1);

        // R8: mid-stream reset discards history
        cur_req = "R8";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(y_out == 0 && y_valid == 0, "R8/R1 reset mid-stream", longint'(y_out), 0);
        rst = 1'b0;
        frame(2047, 1);
        frame(0, 1);
        chk(y_valid == 0 && longint'(y_out) == (htap(0) * 2047 + 16384) >>> 15,
            "R8 first result from fresh history", longint'(y_out), (htap(0) * 2047 + 16384) >>> 15);
        for (int i = 0; i < 20; i++) frame(0, 1);

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule